// File: doc/BRIEF.md
# Block-Transfer Host Interrupt Mask Controller

This block owns the host-visible interrupt mask of a block-transfer message interface and drives the level-sensitive interrupt line towards the host. The register has two live bits: an enable and a pending flag. The interrupt line is high exactly while the pending flag is set. The host writes the mask to arm or disarm the interrupt and to acknowledge it. The rest of the interface supplies the two attention status bits, a global interrupt-allow input and single-cycle event pulses. The block does not decide when attention is raised. It only reacts to these inputs.

The behaviour is held in a three-state machine, and the state encoding is the mask read value:
- `ST_OFF` (00): disabled.
- `ST_ARMED` (01): enabled, nothing pending.
- `ST_FIRED` (11): enabled and pending.

The transitions are:
- *enable*: `ST_OFF` goes to `ST_ARMED`, or to `ST_FIRED` when attention is already standing.
- *disable*: any state goes to `ST_OFF`.
- *raise*: `ST_ARMED` goes to `ST_FIRED` on a response post or an SMS rise.
- *acknowledge*: `ST_FIRED` goes to `ST_ARMED` on a write-one-to-clear.
- *drop*: `ST_FIRED` goes to `ST_ARMED` on an SMS fall.
- *reset*: any state goes to `ST_OFF`.

Top module: `bt_irqmask`

## Requirements
- R1: `mask_rdata` bit 0 is the enable and bit 1 is the pending flag. Pending is never set while the enable is 0. `host_irq` equals the pending flag in every cycle. Both change one clock edge after the event that causes them.
- R2: A write with bit 0 = 1 and bit 1 = 0 while disabled enables the interrupt. If `atn_rsp` or `atn_sms` is high in that cycle, pending is set at the same edge; otherwise pending stays clear.
- R3: A write with bit 0 = 0 clears both the enable and the pending flag. This has priority over every event in the same cycle.
- R4: While pending, a write with bit 0 = 1 and bit 1 = 1 clears pending and keeps the enable. A write with bit 1 = 0 leaves pending set. While not pending, bit 1 has no effect.
- R5: A `rsp_posted` pulse sets pending only if `irq_allow` is 1 and the enable was already 1. While disabled, or with `irq_allow` = 0, the pulse has no effect.
- R6: A `sms_rise` pulse sets pending only if `sms_irq_req` is 1, `atn_rsp` is 0 and the enable is 1. `irq_allow` is not consulted for this event.
- R7: A `sms_fall` pulse clears pending when `atn_rsp` is 0, and has no effect when `atn_rsp` is 1.
- R8: Reset (`rst_n` low) clears the enable, the pending flag and `host_irq`.
- R9: If an acknowledge write and a raising event fall in the same cycle, pending stays set, so the new event is not lost.
- R10: A single write of bit 0 = 1 and bit 1 = 1 while disabled, with attention standing, leaves the block enabled and not pending. The enable is applied first and the acknowledge second.
- R11: Write bits above bit 1 are ignored, and `mask_rdata` bits above bit 1 always read 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| mask_wr | input | 1 | Host write strobe for the mask register |
| mask_wdata | input | DATA_W | Host write data: bit 0 = enable, bit 1 = acknowledge |
| atn_rsp | input | 1 | Response attention status bit |
| atn_sms | input | 1 | SMS attention status bit |
| irq_allow | input | 1 | Global interrupt-allow |
| rsp_posted | input | 1 | Single-cycle pulse: a response has been posted |
| sms_rise | input | 1 | Single-cycle pulse: SMS attention became set |
| sms_irq_req | input | 1 | Qualifies `sms_rise`: an interrupt was requested |
| sms_fall | input | 1 | Single-cycle pulse: SMS attention was cleared |
| mask_rdata | output | DATA_W | Mask register read value |
| host_irq | output | 1 | Registered active-high interrupt level |

## Verification
A host write to the mask and an event pulse from the interface can land in the same clock cycle. The outcome then rests on the priority order: disable first, then raise, then acknowledge or drop. The bench provokes this overlap in three ways:
- an acknowledge write in the same cycle as a `rsp_posted` pulse;
- a disable write in the same cycle as a posting;
- an enable-plus-acknowledge write with attention standing.

Each is judged by the mask read value and `host_irq` one edge later.

// File: rtl/bt_irqmask_pkg.sv
package bt_irqmask_pkg;
    localparam int EN_BIT  = 0;
    localparam int ACK_BIT = 1;
    localparam int LIVE_W  = 2;

    // Encoding equals the mask read value {pending, enable}.
    typedef enum logic [LIVE_W-1:0] {
        ST_OFF   = 2'b00,
        ST_ARMED = 2'b01,
        ST_FIRED = 2'b11
    } irq_state_e;
endpackage

// File: rtl/bt_irqmask_evt.sv
module bt_irqmask_evt (
    input  logic atn_rsp,
    input  logic irq_allow,
    input  logic rsp_posted,
    input  logic sms_rise,
    input  logic sms_irq_req,
    input  logic sms_fall,
    output logic raise,
    output logic drop
);
    logic rsp_raise;
    logic sms_raise;

    always_comb begin
        rsp_raise = rsp_posted & irq_allow;
        sms_raise = sms_rise & sms_irq_req & ~atn_rsp;
        raise     = rsp_raise | sms_raise;
        drop      = sms_fall & ~atn_rsp;
    end
endmodule

// File: rtl/bt_irqmask_fsm.sv
module bt_irqmask_fsm
    import bt_irqmask_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] mask_wdata,
    input  logic              atn_any,
    input  logic              raise,
    input  logic              drop,
    output irq_state_e        state,
    output logic              irq
);
    irq_state_e state_q;
    irq_state_e state_d;
    logic       wr_dis;
    logic       wr_en;
    logic       wr_ack;

    always_comb begin
        wr_dis = mask_wr & ~mask_wdata[EN_BIT];
        wr_en  = mask_wr &  mask_wdata[EN_BIT];
        wr_ack = wr_en   &  mask_wdata[ACK_BIT];
    end

    always_comb begin
        state_d = state_q;
        unique case (state_q)
            ST_OFF: begin
                if (wr_en) begin
                    state_d = (atn_any && !wr_ack) ? ST_FIRED : ST_ARMED;
                end
            end
            ST_ARMED: begin
                if (wr_dis) begin
                    state_d = ST_OFF;
                end else if (raise) begin
                    state_d = ST_FIRED;
                end
            end
            ST_FIRED: begin
                if (wr_dis) begin
                    state_d = ST_OFF;
                end else if (raise) begin
                    state_d = ST_FIRED;
                end else if (wr_ack || drop) begin
                    state_d = ST_ARMED;
                end
            end
            default: state_d = ST_OFF;
        endcase
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q <= ST_OFF;
        end else begin
            state_q <= state_d;
        end
    end

    always_ff @(posedge clk) begin
        if (!rst_n) begin
            irq <= 1'b0;
        end else begin
            irq <= (state_d == ST_FIRED);
        end
    end

    assign state = state_q;
endmodule

// File: rtl/bt_irqmask.sv
module bt_irqmask
    import bt_irqmask_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              mask_wr,
    input  logic [DATA_W-1:0] mask_wdata,
    input  logic              atn_rsp,
    input  logic              atn_sms,
    input  logic              irq_allow,
    input  logic              rsp_posted,
    input  logic              sms_rise,
    input  logic              sms_irq_req,
    input  logic              sms_fall,
    output logic [DATA_W-1:0] mask_rdata,
    output logic              host_irq
);
    localparam int PAD_W = DATA_W - LIVE_W;

    logic       raise;
    logic       drop;
    irq_state_e state;

    bt_irqmask_evt i_evt (
        .atn_rsp     (atn_rsp),
        .irq_allow   (irq_allow),
        .rsp_posted  (rsp_posted),
        .sms_rise    (sms_rise),
        .sms_irq_req (sms_irq_req),
        .sms_fall    (sms_fall),
        .raise       (raise),
        .drop        (drop)
    );

    bt_irqmask_fsm #(.DATA_W(DATA_W)) i_fsm (
        .clk        (clk),
        .rst_n      (rst_n),
        .mask_wr    (mask_wr),
        .mask_wdata (mask_wdata),
        .atn_any    (atn_rsp | atn_sms),
        .raise      (raise),
        .drop       (drop),
        .state      (state),
        .irq        (host_irq)
    );

    assign mask_rdata = {{PAD_W{1'b0}}, LIVE_W'(state)};
endmodule

// File: rtl/bt_irqmask_chk.sv
module bt_irqmask_chk #(
    parameter int DATA_W = 8
) (
    input logic              clk,
    input logic              rst_n,
    input logic              mask_wr,
    input logic [DATA_W-1:0] mask_wdata,
    input logic              atn_rsp,
    input logic              atn_sms,
    input logic              irq_allow,
    input logic              rsp_posted,
    input logic              sms_rise,
    input logic              sms_irq_req,
    input logic              sms_fall,
    input logic [DATA_W-1:0] mask_rdata,
    input logic              host_irq
);
    logic any_raise;
    logic dis_wr;
    assign any_raise = (rsp_posted & irq_allow) | (sms_rise & sms_irq_req & ~atn_rsp);
    assign dis_wr    = mask_wr & ~mask_wdata[0];

    assert_irq_tracks_pending_R1: assert property (@(posedge clk) disable iff (!rst_n)
        host_irq == mask_rdata[1]);

    assert_pending_needs_enable_R1: assert property (@(posedge clk) disable iff (!rst_n)
        mask_rdata[1] |-> mask_rdata[0]);

    assert_enable_fires_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata[1:0] == 2'b01 && !mask_rdata[0] && (atn_rsp || atn_sms))
        |=> mask_rdata[1]);

    assert_disable_clears_R3: assert property (@(posedge clk) disable iff (!rst_n)
        dis_wr |=> (mask_rdata[1:0] == 2'b00 && !host_irq));

    assert_ack_clears_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_wr && mask_wdata[1:0] == 2'b11 && mask_rdata[1] && !any_raise)
        |=> (mask_rdata[1:0] == 2'b01));

    assert_post_fires_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rdata[0] && rsp_posted && irq_allow && !dis_wr) |=> mask_rdata[1]);

    assert_sms_fires_R6: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rdata[0] && sms_rise && sms_irq_req && !atn_rsp && !dis_wr) |=> mask_rdata[1]);

    assert_sms_drop_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rdata[1] && sms_fall && !atn_rsp && !mask_wr && !any_raise) |=> !mask_rdata[1]);

    assert_ack_loses_to_raise_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (mask_rdata[1] && mask_wr && mask_wdata[1:0] == 2'b11 && any_raise) |=> mask_rdata[1]);

    assert_enable_ack_same_write_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (!mask_rdata[0] && mask_wr && mask_wdata[1:0] == 2'b11) |=> (mask_rdata[1:0] == 2'b01));
endmodule

bind bt_irqmask bt_irqmask_chk #(.DATA_W(DATA_W)) i_chk (
    .clk         (clk),
    .rst_n       (rst_n),
    .mask_wr     (mask_wr),
    .mask_wdata  (mask_wdata),
    .atn_rsp     (atn_rsp),
    .atn_sms     (atn_sms),
    .irq_allow   (irq_allow),
    .rsp_posted  (rsp_posted),
    .sms_rise    (sms_rise),
    .sms_irq_req (sms_irq_req),
    .sms_fall    (sms_fall),
    .mask_rdata  (mask_rdata),
    .host_irq    (host_irq)
);

// File: tb/test_bt_irqmask.sv
module test_bt_irqmask;
    localparam int DATA_W = 8;
    localparam int NVEC   = 20;

    // {wr, wdata[1:0], atn_rsp, atn_sms, irq_allow, rsp_posted,
    //  sms_rise, sms_irq_req, sms_fall, exp_pending, exp_enable}
    localparam logic [11:0] VEC [NVEC] = '{
        12'b0_00_00_00_000_00,  // idle after reset
        12'b0_00_00_11_000_00,  // post while disabled: ignored
        12'b1_01_00_00_000_01,  // enable, no attention
        12'b0_00_00_01_000_01,  // post, allow=0
        12'b0_00_00_11_000_11,  // post, allow=1
        12'b1_11_00_00_000_01,  // acknowledge
        12'b0_00_10_00_110_01,  // sms rise blocked by atn_rsp
        12'b0_00_00_00_100_01,  // sms rise without request
        12'b0_00_01_00_110_11,  // sms rise fires
        12'b0_00_10_00_001_11,  // sms fall blocked by atn_rsp
        12'b0_00_00_00_001_01,  // sms fall drops pending
        12'b0_00_00_11_000_11,  // post fires
        12'b1_11_00_11_000_11,  // ack and post same cycle
        12'b1_01_00_00_000_11,  // write without ack bit
        12'b1_00_00_00_000_00,  // disable
        12'b1_01_01_00_000_11,  // enable with sms attention
        12'b1_00_00_11_000_00,  // disable beats post
        12'b1_11_10_00_000_01,  // enable+ack with attention
        12'b1_10_00_00_000_00,  // bit0=0 disables
        12'b1_01_10_00_000_11   // enable with rsp attention
    };

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              mask_wr = 1'b0;
    logic [DATA_W-1:0] mask_wdata = '0;
    logic              atn_rsp = 1'b0;
    logic              atn_sms = 1'b0;
    logic              irq_allow = 1'b0;
    logic              rsp_posted = 1'b0;
    logic              sms_rise = 1'b0;
    logic              sms_irq_req = 1'b0;
    logic              sms_fall = 1'b0;
    logic [DATA_W-1:0] mask_rdata;
    logic              host_irq;

    int n_checks = 0;
    int n_fail   = 0;
    bit finished = 1'b0;

    always #2 clk = ~clk;

    bt_irqmask #(.DATA_W(DATA_W)) i_bt_irqmask (
        .clk         (clk),
        .rst_n       (rst_n),
        .mask_wr     (mask_wr),
        .mask_wdata  (mask_wdata),
        .atn_rsp     (atn_rsp),
        .atn_sms     (atn_sms),
        .irq_allow   (irq_allow),
        .rsp_posted  (rsp_posted),
        .sms_rise    (sms_rise),
        .sms_irq_req (sms_irq_req),
        .sms_fall    (sms_fall),
        .mask_rdata  (mask_rdata),
        .host_irq    (host_irq)
    );

    task automatic check(string req, logic [31:0] act, logic [31:0] exp);
        n_checks++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s: actual %0h expected %0h", req, act, exp);
        end
    endtask

    function automatic string vec_req(int i);
        case (i)
            0:          return "R8";
            1, 3, 4, 11: return "R5";
            2, 15, 19:  return "R2";
            5, 13:      return "R4";
            6, 7, 8:    return "R6";
            9, 10:      return "R7";
            12:         return "R9";
            14, 16, 18: return "R3";
            17:         return "R10";
            default:    return "R1";
        endcase
    endfunction

    task automatic drive(logic [11:0] v, logic [DATA_W-1:0] wd);
        @(negedge clk);
        mask_wr     = v[11];
        mask_wdata  = wd;
        atn_rsp     = v[8];
        atn_sms     = v[7];
        irq_allow   = v[6];
        rsp_posted  = v[5];
        sms_rise    = v[4];
        sms_irq_req = v[3];
        sms_fall    = v[2];
        @(posedge clk);
        #1;
    endtask

    task automatic finish_run();
        if (!finished) begin
            finished = 1'b1;
            $display("%0d/%0d checks passed", n_checks - n_fail, n_checks);
            $finish;
        end
    endtask

    initial begin
        #(4 * 200000);
        n_checks++;
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        finish_run();
    end

    initial begin
        repeat (3) @(posedge clk);
        #1;
        check("R8 reset mask", 32'(mask_rdata), 32'h0);
        check("R8 reset irq", 32'(host_irq), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;

        for (int i = 0; i < NVEC; i++) begin
            drive(VEC[i], {{(DATA_W-2){1'b0}}, VEC[i][10:9]});
            check(vec_req(i), 32'(mask_rdata[1:0]), 32'(VEC[i][1:0]));
            check("R1 irq level", 32'(host_irq), 32'(VEC[i][1]));
        end

        // R11: upper write bits ignored, upper read bits zero
        drive(12'b1_00_00_00_000_00, 8'hFC);
        check("R11 upper bits, disable", 32'(mask_rdata), 32'h00);
        drive(12'b1_00_00_00_000_00, 8'hF9);
        check("R11 upper bits, enable", 32'(mask_rdata), 32'h01);

        // R8: reset while pending
        drive(12'b0_00_00_11_000_00, 8'h00);
        check("R5 pending before reset", 32'(mask_rdata), 32'h03);
        drive(12'b0_00_00_00_000_00, 8'h00);
        @(negedge clk);
        rst_n = 1'b0;
        @(posedge clk);
        #1;
        check("R8 reset clears mask", 32'(mask_rdata), 32'h00);
        check("R8 reset clears irq", 32'(host_irq), 32'h0);
        @(negedge clk);
        rst_n = 1'b1;
        drive(12'b0_00_00_11_000_00, 8'h00);
        check("R5 post after reset ignored", 32'(mask_rdata), 32'h00);

        drive(12'b0_00_00_00_000_00, 8'h00);
        finish_run();
    end
endmodule